// File: doc/BRIEF.md
# Boxed Half-Precision Round-to-Integral Unit

This unit takes a half-precision floating-point operand held in the low 16 bits of a 64-bit floating-point register and rounds it to an integral value. The result stays in half-precision format and goes back into a 64-bit word. Before rounding, the upper 48 bits of the source are checked. If they are not all ones, the operand is replaced by the canonical half-precision NaN. The result always leaves with its upper 48 bits set.

The unit is a single registered stage. The result and the invalid and inexact flags are captured on the clock edge where the input strobe is high. The output strobe follows one cycle later. A 3-bit field selects one of five rounding directions. The other three codes are illegal.

Top module: `fp16_boxed_rint`

## Requirements
- R1: When `src_i[63:16]` is not all ones, the operand is treated as the quiet NaN 0x7E00. This includes a source that carries a 32-bit box, 0xFFFFFFFF in bits 63:32 with zeros above bit 15. The result is then 0xFFFFFFFFFFFF7E00 with no flag raised. An all-zero source gives exactly that value.
- R2: Every result has bits 63:16 equal to all ones.
- R3: `out_valid_o` is high exactly one cycle after `in_valid_i` was high. The result and flags change only on an edge where `in_valid_i` is high, and hold otherwise.
- R4: A NaN input (exponent field 31, fraction nonzero) gives 0x7E00. A signalling NaN (fraction bit 9 clear) also raises `invalid_o`. A quiet NaN (fraction bit 9 set) raises no flag.
- R5: Infinities, zeros of either sign and finite inputs with exponent field 25 or more are returned unchanged, with no flag raised.
- R6: Mode 000 rounds to nearest and breaks ties toward the even integer.
- R7: Mode 001 rounds toward zero.
- R8: Mode 010 rounds toward minus infinity. Mode 011 rounds toward plus infinity.
- R9: Mode 100 rounds to nearest and breaks ties away from zero.
- R10: Mode codes 101, 110 and 111 are illegal. For any operand they give 0x7E00 with `invalid_o` set and `inexact_o` clear.
- R11: `inexact_o` is set exactly when a finite operand's rounded value differs from it. It is never set together with `invalid_o`.
- R12: A result that rounds to zero keeps the operand's sign (0x0000 or 0x8000). A carry out of the significand moves into the exponent correctly, for example 0x5FFF gives 0x6000 under mode 000.
- R13: After reset, `out_valid_o`, `result_o`, `invalid_o` and `inexact_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operand strobe |
| src_i | input | 64 | Boxed source register value |
| rmode_i | input | 3 | Rounding mode code |
| out_valid_o | output | 1 | Result strobe, one cycle after the operand |
| result_o | output | 64 | Boxed rounded result |
| invalid_o | output | 1 | Invalid-operation flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
A wrong box test shows up as a canonical NaN where a number was expected, or the reverse. A wrong rounding increment or sticky bit shows up as a result that is off by one unit in the last place, or a wrong inexact flag. Both appear in the same result word one cycle after the strobe. A mistake in renormalising the rounded magnitude appears only at boundaries: the exponent step at 512, subnormals that round up to one, and negative operands that round to zero. These cases are driven one at a time, so each fault appears on the cycle after the operand that triggers it.

// File: rtl/fp16_boxed_rint.sv
module fp16_boxed_rint #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [2:0]      rmode_i,
  output logic            out_valid_o,
  output logic [XLEN-1:0] result_o,
  output logic            invalid_o,
  output logic            inexact_o
);
  localparam int HW = 16;
  localparam int BW = XLEN - HW;
  localparam logic [HW-1:0] CANON = 16'h7E00;

  logic          boxed;
  logic [HW-1:0] op;
  logic          sgn;
  logic [4:0]    ex;
  logic [9:0]    fr;

  assign boxed = &src_i[XLEN-1:HW];
  assign op    = boxed ? src_i[HW-1:0] : CANON;
  assign sgn   = op[15];
  assign ex    = op[14:10];
  assign fr    = op[9:0];

  logic        bad_mode;
  logic        is_nan, is_snan, is_inf, is_zero, is_big;
  assign bad_mode = rmode_i > 3'd4;
  assign is_nan   = (ex == 5'd31) && (fr != 10'd0);
  assign is_snan  = is_nan && !fr[9];
  assign is_inf   = (ex == 5'd31) && (fr == 10'd0);
  assign is_zero  = (ex == 5'd0) && (fr == 10'd0);
  assign is_big   = (ex >= 5'd25) && !is_nan && !is_inf;

  logic [4:0]  ex_eff;
  logic [4:0]  shamt;
  logic [10:0] mant;
  logic [35:0] aligned;
  logic [10:0] ipart;
  logic        rbit, sticky, lost;
  assign ex_eff  = (ex == 5'd0) ? 5'd1 : ex;
  assign shamt   = 5'd25 - ex_eff;
  assign mant    = {ex != 5'd0, fr};
  assign aligned = {mant, 25'd0} >> shamt;
  assign ipart   = aligned[35:25];
  assign rbit    = aligned[24];
  assign sticky  = |aligned[23:0];
  assign lost    = rbit | sticky;

  logic bump;
  always_comb begin
    case (rmode_i)
      3'd0:    bump = rbit & (sticky | ipart[0]);
      3'd1:    bump = 1'b0;
      3'd2:    bump = sgn & lost;
      3'd3:    bump = ~sgn & lost;
      3'd4:    bump = rbit;
      default: bump = 1'b0;
    endcase
  end

  logic [11:0] mag;
  assign mag = {1'b0, ipart} + {11'd0, bump};

  logic [3:0]    msb;
  logic [11:0]   norm;
  logic [HW-1:0] rounded;
  always_comb begin
    msb = 4'd0;
    for (int i = 0; i < 12; i++)
      if (mag[i]) msb = 4'(i);
    norm = mag << (4'd10 - msb);
    if (mag == 12'd0) rounded = {sgn, 15'd0};
    else              rounded = {sgn, 5'd15 + {1'b0, msb}, norm[9:0]};
  end

  logic [HW-1:0] res_d;
  logic          inv_d, inx_d;
  always_comb begin
    res_d = op;
    inv_d = 1'b0;
    inx_d = 1'b0;
    if (bad_mode) begin
      res_d = CANON;
      inv_d = 1'b1;
    end else if (is_nan) begin
      res_d = CANON;
      inv_d = is_snan;
    end else if (!(is_inf || is_zero || is_big)) begin
      res_d = rounded;
      inx_d = lost;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      invalid_o   <= 1'b0;
      inexact_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o  <= {{BW{1'b1}}, res_d};
        invalid_o <= inv_d;
        inexact_o <= inx_d;
      end
    end
  end
endmodule

// File: rtl/fp16_boxed_rint_chk.sv
module fp16_boxed_rint_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid_i,
  input logic [XLEN-1:0] src_i,
  input logic [2:0]      rmode_i,
  input logic            out_valid_o,
  input logic [XLEN-1:0] result_o,
  input logic            invalid_o,
  input logic            inexact_o
);
  localparam logic [XLEN-1:0] CANON_BOXED = {{(XLEN-16){1'b1}}, 16'h7E00};

  // R1
  unboxed_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !(&src_i[XLEN-1:16]) && rmode_i <= 3'd4)
      |=> (result_o == CANON_BOXED && !invalid_o && !inexact_o));

  // R2
  box_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (&result_o[XLEN-1:16]));

  // R3
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);

  // R3
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o);

  // R3
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> ($stable(result_o) && $stable(invalid_o) && $stable(inexact_o)));

  // R10
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && rmode_i > 3'd4) |=> (invalid_o && !inexact_o && result_o == CANON_BOXED));

  // R11
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> !(invalid_o && inexact_o));
endmodule

bind fp16_boxed_rint fp16_boxed_rint_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .src_i(src_i),
  .rmode_i(rmode_i), .out_valid_o(out_valid_o), .result_o(result_o),
  .invalid_o(invalid_o), .inexact_o(inexact_o)
);

// File: tb/fp16_boxed_rint_bench.sv
module fp16_boxed_rint_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [63:0] src_i = '0;
  logic [2:0]  rmode_i = '0;
  logic        out_valid_o;
  logic [63:0] result_o;
  logic        invalid_o, inexact_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [47:0] BOX = 48'hFFFF_FFFF_FFFF;

  always #10 clk = ~clk;

  fp16_boxed_rint u_fp16_boxed_rint (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .src_i(src_i),
    .rmode_i(rmode_i), .out_valid_o(out_valid_o), .result_o(result_o),
    .invalid_o(invalid_o), .inexact_o(inexact_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [63:0] src, logic [2:0] rm,
                        logic [15:0] exp_h, logic exp_inv, logic exp_inx);
    @(negedge clk);
    src_i = src; rmode_i = rm; in_valid_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
    check({req, " valid"}, {63'd0, out_valid_o}, 64'd1);
    check({req, " result"}, result_o, {BOX, exp_h});
    check({req, " invalid"}, {63'd0, invalid_o}, {63'd0, exp_inv});
    check({req, " inexact"}, {63'd0, inexact_o}, {63'd0, exp_inx});
  endtask

  task automatic t_reset();
    check("R13 valid", {63'd0, out_valid_o}, 64'd0);
    check("R13 result", result_o, 64'd0);
    check("R13 flags", {62'd0, invalid_o, inexact_o}, 64'd0);
  endtask

  task automatic t_box();
    run_op("R1 zero src", 64'd0, 3'd0, 16'h7E00, 0, 0);
    run_op("R1 32bit box", 64'hFFFF_FFFF_0000_3C00, 3'd0, 16'h7E00, 0, 0);
    run_op("R1 top bit clear", 64'h7FFF_FFFF_FFFF_3E00, 3'd3, 16'h7E00, 0, 0);
    run_op("R2 boxed ok", {BOX, 16'h3C00}, 3'd0, 16'h3C00, 0, 0);
  endtask

  task automatic t_hold();
    @(negedge clk);
    src_i = {BOX, 16'h7D00}; rmode_i = 3'd7;
    repeat (3) @(negedge clk);
    check("R3 idle valid", {63'd0, out_valid_o}, 64'd0);
    check("R3 hold result", result_o, {BOX, 16'h3C00});
    check("R3 hold flags", {62'd0, invalid_o, inexact_o}, 64'd0);
  endtask

  task automatic t_nan();
    run_op("R4 snan", {BOX, 16'h7D00}, 3'd0, 16'h7E00, 1, 0);
    run_op("R4 neg snan", {BOX, 16'hFC01}, 3'd1, 16'h7E00, 1, 0);
    run_op("R4 qnan", {BOX, 16'h7E01}, 3'd0, 16'h7E00, 0, 0);
  endtask

  task automatic t_pass();
    run_op("R5 +inf", {BOX, 16'h7C00}, 3'd0, 16'h7C00, 0, 0);
    run_op("R5 -inf", {BOX, 16'hFC00}, 3'd2, 16'hFC00, 0, 0);
    run_op("R5 -zero", {BOX, 16'h8000}, 3'd3, 16'h8000, 0, 0);
    run_op("R5 1024", {BOX, 16'h6400}, 3'd3, 16'h6400, 0, 0);
    run_op("R5 max", {BOX, 16'h7BFF}, 3'd4, 16'h7BFF, 0, 0);
  endtask

  task automatic t_rne();
    run_op("R6 2.5", {BOX, 16'h4100}, 3'd0, 16'h4000, 0, 1);
    run_op("R6 1.5", {BOX, 16'h3E00}, 3'd0, 16'h4000, 0, 1);
    run_op("R6 0.5", {BOX, 16'h3800}, 3'd0, 16'h0000, 0, 1);
    run_op("R11 exact 3.0", {BOX, 16'h4200}, 3'd0, 16'h4200, 0, 0);
  endtask

  task automatic t_rtz();
    run_op("R7 1.5", {BOX, 16'h3E00}, 3'd1, 16'h3C00, 0, 1);
    run_op("R7 -1.5", {BOX, 16'hBE00}, 3'd1, 16'hBC00, 0, 1);
    run_op("R7 511.75", {BOX, 16'h5FFF}, 3'd1, 16'h5FFC, 0, 1);
  endtask

  task automatic t_directed();
    run_op("R8 down 1.5", {BOX, 16'h3E00}, 3'd2, 16'h3C00, 0, 1);
    run_op("R8 down -1.5", {BOX, 16'hBE00}, 3'd2, 16'hC000, 0, 1);
    run_op("R8 down -0.25", {BOX, 16'hB400}, 3'd2, 16'hBC00, 0, 1);
    run_op("R8 up 1.5", {BOX, 16'h3E00}, 3'd3, 16'h4000, 0, 1);
    run_op("R8 up -1.5", {BOX, 16'hBE00}, 3'd3, 16'hBC00, 0, 1);
    run_op("R8 up min subnormal", {BOX, 16'h0001}, 3'd3, 16'h3C00, 0, 1);
  endtask

  task automatic t_rmm();
    run_op("R9 2.5", {BOX, 16'h4100}, 3'd4, 16'h4200, 0, 1);
    run_op("R9 -2.5", {BOX, 16'hC100}, 3'd4, 16'hC200, 0, 1);
    run_op("R9 0.5", {BOX, 16'h3800}, 3'd4, 16'h3C00, 0, 1);
  endtask

  task automatic t_badmode();
    run_op("R10 mode5", {BOX, 16'h3C00}, 3'd5, 16'h7E00, 1, 0);
    run_op("R10 mode6", {BOX, 16'h3E00}, 3'd6, 16'h7E00, 1, 0);
    run_op("R10 mode7 inf", {BOX, 16'h7C00}, 3'd7, 16'h7E00, 1, 0);
  endtask

  task automatic t_signzero();
    run_op("R12 -0.25 rne", {BOX, 16'hB400}, 3'd0, 16'h8000, 0, 1);
    run_op("R12 -0.25 up", {BOX, 16'hB400}, 3'd3, 16'h8000, 0, 1);
    run_op("R12 0.25 down", {BOX, 16'h3400}, 3'd2, 16'h0000, 0, 1);
    run_op("R12 carry 511.75", {BOX, 16'h5FFF}, 3'd0, 16'h6000, 0, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_box();
    t_hold();
    t_nan();
    t_pass();
    t_rne();
    t_rtz();
    t_directed();
    t_rmm();
    t_badmode();
    t_signzero();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule